// File: doc/BRIEF.md
# Keyed Page Integrity Tag Unit

This unit produces a 32-bit secret integrity tag for a memory page, keyed by a 256-byte secret held in write-only registers inside the unit. Firmware loads the key as sixty-four 32-bit words through a simple write port. It can also wipe the key in a single cycle. A page operation is started with a mode bit and a size bit. Page words then stream in over a valid/ready handshake.

In generate mode the finished tag appears on the output for one cycle, so the caller can store it in trusted internal memory before the page is evicted. In verify mode, used when a page returns from untrusted external memory, the unit compares the fresh tag with a stored tag supplied at start. It reports only pass or fail. On a mismatch it raises a sticky tamper output meant to request an immediate platform shutdown. The tag arithmetic is carry-less GF(2) multiply-reduce over 32-bit words, each word whitened with a position-selected key word.

Top module: `tagu_top`

## Requirements
- R1: Key word `key_wr_idx` (0..63) takes `key_wr_data` on a `key_wr_en` cycle. The key counts as loaded only once all 64 indices have been written since reset or the last clear.
- R2: A `key_clear` pulse zeroes every key word and forgets all writes in one cycle. A start after the clear reports a key error.
- R3: A `start` while the key is not loaded gives, one cycle later, a one-cycle `done` with `key_err`=1. In that cycle `tag_valid` and `verify_pass` are 0, `tag_out` is 0, and no words are accepted.
- R4: `page_sel`=0 selects a page of 256 words (1 KB) and `page_sel`=1 selects 1024 words (4 KB). `done` is asserted exactly in the cycle after the last word is accepted, and never before it.
- R5: The tag starts at 0. For word i it becomes mul(tag XOR word XOR K[i mod 64], 0x9E3779B9), where mul is the carry-less product reduced by x^32+x^7+x^3+x^2+1.
- R6: In generate mode (`mode`=0), `tag_out` carries the tag with `tag_valid`=1 in the `done` cycle. At all other times `tag_out` is 0.
- R7: In verify mode (`mode`=1), a tag equal to `ref_tag` (captured at start) sets `verify_pass`=1 in the `done` cycle and leaves `tamper` unchanged.
- R8: In verify mode a mismatch sets `tamper` in the `done` cycle, with `verify_pass`=0. `tamper` then stays 1 until reset. The verify tag is never driven on `tag_out`.
- R9: While an operation runs, `start` and key writes are ignored. `in_ready` is 1 only while running.
- R10: Cycles with `in_valid`=0 leave the tag and the word count untouched, so idle gaps in the stream do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_wr_en | input | 1 | Key word write strobe |
| key_wr_idx | input | 6 | Key word index |
| key_wr_data | input | 32 | Key word value |
| key_clear | input | 1 | Wipe all key words |
| start | input | 1 | Begin an operation |
| mode | input | 1 | 0 generate, 1 verify |
| page_sel | input | 1 | 0 = 256 words, 1 = 1024 words |
| ref_tag | input | 32 | Stored tag for verify |
| in_valid | input | 1 | Page word valid |
| in_data | input | 32 | Page word |
| in_ready | output | 1 | Unit accepts a word |
| busy | output | 1 | Operation running |
| done | output | 1 | End-of-operation pulse |
| key_err | output | 1 | Start refused, key not loaded |
| tag_out | output | 32 | Generated tag |
| tag_valid | output | 1 | `tag_out` valid |
| verify_pass | output | 1 | Verify matched |
| tamper | output | 1 | Sticky mismatch alarm |

## Verification
The assertions assume `start` arrives only as a pulse. They also assume the caller streams no more words than the selected page holds. Any word offered while `in_ready` is low is simply not taken. The bench raises `start` for one cycle per operation, idle or busy. It drops `in_valid` as soon as the last word of the page is taken, so the beat count never runs past the page size the checker bounds.

// File: rtl/tagu_pkg.sv
package tagu_pkg;
  localparam int TAG_W      = 32;
  localparam int KEY_WORDS  = 64;
  localparam int KIDX_W     = $clog2(KEY_WORDS);
  localparam int WORDS_1K   = 256;
  localparam int WORDS_4K   = 1024;
  localparam int CNT_W      = $clog2(WORDS_4K);
  localparam logic [TAG_W-1:0] REDUCE_POLY = 32'h0000_008D;
  localparam logic [TAG_W-1:0] HASH_MULT   = 32'h9E37_79B9;

  typedef enum logic {ST_IDLE, ST_RUN} tagu_state_e;

  // carry-less product of a and b, reduced modulo x^32 + REDUCE_POLY
  function automatic logic [TAG_W-1:0] gf_mul(input logic [TAG_W-1:0] a,
                                              input logic [TAG_W-1:0] b);
    logic [TAG_W-1:0] r;
    r = '0;
    for (int i = TAG_W-1; i >= 0; i--) begin
      r = {r[TAG_W-2:0], 1'b0} ^ (r[TAG_W-1] ? REDUCE_POLY : '0);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  // one absorb step of the keyed hash
  function automatic logic [TAG_W-1:0] fold(input logic [TAG_W-1:0] acc,
                                            input logic [TAG_W-1:0] word,
                                            input logic [TAG_W-1:0] kword);
    return gf_mul(acc ^ word ^ kword, HASH_MULT);
  endfunction
endpackage

// File: rtl/tagu_keyregs.sv
module tagu_keyregs #(
  parameter int NWORDS = 64,
  parameter int W      = 32,
  localparam int IW    = $clog2(NWORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic          clear,
  input  logic          lock,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_word,
  output logic          loaded
);
  logic [W-1:0]      key_q [NWORDS];
  logic [NWORDS-1:0] seen_q;
  logic              wr_ok;

  assign wr_ok = wr_en & ~lock;

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        key_q[g]  <= '0;
        seen_q[g] <= 1'b0;
      end else if (wr_ok && wr_idx == IW'(g)) begin
        key_q[g]  <= wr_data;
        seen_q[g] <= 1'b1;
      end
    end
  end

  assign rd_word = key_q[rd_idx];
  assign loaded  = &seen_q;
endmodule

// File: rtl/tagu_accum.sv
module tagu_accum
  import tagu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             step,
  input  logic [TAG_W-1:0] word,
  input  logic [TAG_W-1:0] kword,
  output logic [TAG_W-1:0] acc_next
);
  logic [TAG_W-1:0] acc_q;

  assign acc_next = fold(acc_q, word, kword);

  always_ff @(posedge clk) begin
    if (!rst_n || init) acc_q <= '0;
    else if (step)      acc_q <= acc_next;
  end
endmodule

// File: rtl/tagu_ctrl.sv
module tagu_ctrl
  import tagu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode,
  input  logic              page_sel,
  input  logic [TAG_W-1:0]  ref_tag,
  input  logic              in_valid,
  input  logic              key_loaded,
  input  logic [TAG_W-1:0]  acc_next,
  output logic              running,
  output logic              beat,
  output logic              last_beat,
  output logic              acc_init,
  output logic [KIDX_W-1:0] word_idx,
  output logic              done,
  output logic              key_err,
  output logic [TAG_W-1:0]  tag_out,
  output logic              tag_valid,
  output logic              verify_pass,
  output logic              tamper
);
  tagu_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             mode_q, big_q;
  logic [TAG_W-1:0] ref_q;
  logic             accept_start;
  logic             mismatch;

  assign running      = (state_q == ST_RUN);
  assign accept_start = (state_q == ST_IDLE) && start;
  assign acc_init     = accept_start;
  assign beat         = running && in_valid;
  assign last_beat    = beat && (cnt_q == (big_q ? CNT_W'(WORDS_4K-1) : CNT_W'(WORDS_1K-1)));
  assign word_idx     = cnt_q[KIDX_W-1:0];
  assign mismatch     = acc_next != ref_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
      big_q   <= 1'b0;
      ref_q   <= '0;
    end else if (accept_start && key_loaded) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
      mode_q  <= mode;
      big_q   <= page_sel;
      ref_q   <= ref_tag;
    end else if (beat) begin
      cnt_q <= cnt_q + 1'b1;
      if (last_beat) state_q <= ST_IDLE;
    end
  end

  // result pulses, registered at the edge that takes the last word
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done        <= 1'b0;
      key_err     <= 1'b0;
      tag_out     <= '0;
      tag_valid   <= 1'b0;
      verify_pass <= 1'b0;
      tamper      <= 1'b0;
    end else begin
      done        <= (accept_start && !key_loaded) || last_beat;
      key_err     <= accept_start && !key_loaded;
      tag_valid   <= last_beat && !mode_q;
      tag_out     <= (last_beat && !mode_q) ? acc_next : '0;
      verify_pass <= last_beat && mode_q && !mismatch;
      if (last_beat && mode_q && mismatch) tamper <= 1'b1;
    end
  end
endmodule

// File: rtl/tagu_top.sv
module tagu_top
  import tagu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr_en,
  input  logic [KIDX_W-1:0] key_wr_idx,
  input  logic [TAG_W-1:0]  key_wr_data,
  input  logic              key_clear,
  input  logic              start,
  input  logic              mode,
  input  logic              page_sel,
  input  logic [TAG_W-1:0]  ref_tag,
  input  logic              in_valid,
  input  logic [TAG_W-1:0]  in_data,
  output logic              in_ready,
  output logic              busy,
  output logic              done,
  output logic              key_err,
  output logic [TAG_W-1:0]  tag_out,
  output logic              tag_valid,
  output logic              verify_pass,
  output logic              tamper
);
  logic              running, beat, last_beat, acc_init, key_loaded;
  logic [KIDX_W-1:0] word_idx;
  logic [TAG_W-1:0]  kword, acc_next;

  tagu_keyregs #(.NWORDS(KEY_WORDS), .W(TAG_W)) u_key (
    .clk(clk), .rst_n(rst_n), .wr_en(key_wr_en), .wr_idx(key_wr_idx),
    .wr_data(key_wr_data), .clear(key_clear), .lock(running),
    .rd_idx(word_idx), .rd_word(kword), .loaded(key_loaded)
  );

  tagu_accum u_acc (
    .clk(clk), .rst_n(rst_n), .init(acc_init), .step(beat),
    .word(in_data), .kword(kword), .acc_next(acc_next)
  );

  tagu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .page_sel(page_sel),
    .ref_tag(ref_tag), .in_valid(in_valid), .key_loaded(key_loaded),
    .acc_next(acc_next), .running(running), .beat(beat), .last_beat(last_beat),
    .acc_init(acc_init), .word_idx(word_idx), .done(done), .key_err(key_err),
    .tag_out(tag_out), .tag_valid(tag_valid), .verify_pass(verify_pass),
    .tamper(tamper)
  );

  assign in_ready = running;
  assign busy     = running;
endmodule

// File: rtl/tagu_checker.sv
module tagu_checker #(
  parameter int MAXW = 1024
) (
  input logic        clk,
  input logic        rst_n,
  input logic        beat,
  input logic        done,
  input logic        key_err,
  input logic        tag_valid,
  input logic [31:0] tag_out,
  input logic        verify_pass,
  input logic        tamper,
  input logic        busy
);
  localparam int BW = $clog2(MAXW + 2);
  logic [BW-1:0] beats_q;

  always_ff @(posedge clk) begin
    if (!rst_n || done) beats_q <= '0;
    else if (beat)      beats_q <= beats_q + 1'b1;
  end

  assert_beats_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    beats_q <= BW'(MAXW));
  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_err_no_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    key_err |-> (done && !tag_valid && !verify_pass && tag_out == '0));
  assert_tag_hidden_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_out != '0) |-> tag_valid);
  assert_tag_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tag_valid |-> done);
  assert_pass_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    verify_pass |-> (done && !tag_valid && !$rose(tamper)));
  assert_tamper_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tamper |=> tamper);
  assert_tamper_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tamper) |-> (done && !verify_pass));
endmodule

bind tagu_top tagu_checker #(.MAXW(tagu_pkg::WORDS_4K)) u_chk (
  .clk(clk), .rst_n(rst_n), .beat(beat), .done(done), .key_err(key_err),
  .tag_valid(tag_valid), .tag_out(tag_out), .verify_pass(verify_pass),
  .tamper(tamper), .busy(busy)
);

// File: tb/tagu_top_tb.sv
module tagu_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_wr_en = 1'b0;
  logic [5:0]  key_wr_idx = '0;
  logic [31:0] key_wr_data = '0;
  logic        key_clear = 1'b0;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic        page_sel = 1'b0;
  logic [31:0] ref_tag = '0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready, busy, done, key_err, tag_valid, verify_pass, tamper;
  logic [31:0] tag_out;

  int vectors = 0;
  int miscompares = 0;
  logic [31:0] kb [64];

  always #5 clk = ~clk;

  tagu_top u_dut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reduction by x^32+x^7+x^3+x^2+1, multiplicand shifted up, multiplier LSB first
  function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r = '0;
    logic [31:0] x = a;
    for (int i = 0; i < 32; i++) begin
      if (b[i]) r ^= x;
      x = x[31] ? ((x << 1) ^ 32'h8D) : (x << 1);
    end
    return r;
  endfunction

  function automatic logic [31:0] page_word(input logic [31:0] seed, input int i);
    return seed ^ (i * 32'h9E37_79B1) ^ (i << 16);
  endfunction

  function automatic logic [31:0] exp_tag(input logic [31:0] seed, input int n);
    logic [31:0] t = '0;
    for (int i = 0; i < n; i++)
      t = ref_mul(t ^ page_word(seed, i) ^ kb[i % 64], 32'h9E37_79B9);
    return t;
  endfunction

  task automatic load_key(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      key_wr_en = 1'b1; key_wr_idx = 6'(i); key_wr_data = kb[i];
    end
    @(negedge clk);
    key_wr_en = 1'b0;
  endtask

  // run one operation; sampled results taken in the cycle after the last word
  task automatic run_op(input bit m, input bit sel, input logic [31:0] seed,
                        input logic [31:0] rt, input bit gaps, input bit poke,
                        input string req);
    int n = sel ? 1024 : 256;
    int i = 0;
    bit gapped = 0, poked = 0, early = 0;
    @(negedge clk);
    start = 1'b1; mode = m; page_sel = sel; ref_tag = rt;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1 && in_ready === 1'b1, {req, " R9 running"}, {31'b0, in_ready}, 32'd1);
    while (i < n) begin
      bit take;
      if (gaps && (i % 5 == 2) && !gapped) begin
        in_valid = 1'b0; gapped = 1;
      end else begin
        in_valid = 1'b1; in_data = page_word(seed, i); gapped = 0;
      end
      if (poke && i == 10 && !poked) begin
        poked = 1; start = 1'b1; mode = ~m;
        key_wr_en = 1'b1; key_wr_idx = 6'd5; key_wr_data = ~kb[5];
      end
      if (done) early = 1;
      take = in_ready && in_valid;
      @(negedge clk);
      start = 1'b0; key_wr_en = 1'b0;
      if (take) i++;
    end
    in_valid = 1'b0;
    check(!early, "R4 no early done", {31'b0, early}, 32'd0);
    check(done === 1'b1 && busy === 1'b0, "R4 done after last word", {31'b0, done}, 32'd1);
  endtask

  task automatic t_reset();
    check(done === 0 && busy === 0 && in_ready === 0 && tamper === 0 && tag_out === 0,
          "R9 reset state", tag_out, 32'd0);
  endtask

  task automatic t_no_key(input string req);
    @(negedge clk);
    start = 1'b1; mode = 1'b0;
    @(negedge clk);
    start = 1'b0;
    check(done === 1 && key_err === 1, {req, " key_err with done"}, {31'b0, key_err}, 32'd1);
    check(tag_valid === 0 && verify_pass === 0 && tag_out === 0 && in_ready === 0,
          "R3 no tag on error", tag_out, 32'd0);
    @(negedge clk);
    check(done === 0 && key_err === 0, "R3 single pulse", {31'b0, done}, 32'd0);
  endtask

  task automatic t_gen(input bit sel, input logic [31:0] seed, input bit gaps,
                       input bit poke, input string req);
    logic [31:0] e = exp_tag(seed, sel ? 1024 : 256);
    run_op(1'b0, sel, seed, 32'h0, gaps, poke, req);
    check(tag_valid === 1 && tag_out === e, {req, " R5 R6 tag"}, tag_out, e);
    @(negedge clk);
    check(tag_out === 0 && tag_valid === 0, "R6 tag cleared", tag_out, 32'd0);
  endtask

  task automatic t_verify(input bit sel, input logic [31:0] seed, input bit good);
    logic [31:0] e = exp_tag(seed, sel ? 1024 : 256);
    run_op(1'b1, sel, seed, good ? e : e ^ 32'h0000_0100, 1'b0, 1'b0, "verify");
    check(tag_out === 0 && tag_valid === 0, "R8 verify tag hidden", tag_out, 32'd0);
    if (good) begin
      check(verify_pass === 1 && tamper === 0, "R7 pass", {31'b0, verify_pass}, 32'd1);
    end else begin
      check(verify_pass === 0 && tamper === 1, "R8 tamper", {31'b0, tamper}, 32'd1);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) kb[i] = (i * 32'h0101_0107) ^ 32'hA5C3_0F11;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_key("R3");
    load_key(63);
    t_no_key("R1 partial key");
    load_key(64);
    t_gen(1'b0, 32'h1234_5678, 1'b0, 1'b0, "R4 1KB");
    t_gen(1'b1, 32'h1234_5678, 1'b0, 1'b0, "R4 4KB");
    t_gen(1'b0, 32'hDEAD_BEEF, 1'b1, 1'b0, "R10 gaps");
    t_gen(1'b0, 32'h0BAD_F00D, 1'b0, 1'b1, "R9 start/key write while busy");
    t_gen(1'b0, 32'h0BAD_F00D, 1'b0, 1'b0, "R9 key unchanged");
    t_verify(1'b0, 32'h5555_AAAA, 1'b1);
    t_verify(1'b1, 32'h7777_1111, 1'b1);
    t_verify(1'b0, 32'h5555_AAAA, 1'b0);
    t_gen(1'b0, 32'h0000_0001, 1'b0, 1'b0, "R8 after tamper");
    check(tamper === 1, "R8 sticky", {31'b0, tamper}, 32'd1);
    @(negedge clk);
    key_clear = 1'b1;
    @(negedge clk);
    key_clear = 1'b0;
    t_no_key("R2 after clear");
    check(tamper === 1, "R8 sticky after clear", {31'b0, tamper}, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    vectors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule